// File: doc/BRIEF.md
# I2C General Call Reset Decoder

This block sits on the target side of an I2C bus, behind a shared bit-level front end that already recovers START and STOP conditions, assembles received bytes and marks the end of each acknowledge bit. The decoder looks only for the general call write. It waits for an address byte of all zeroes with the read/write bit clear, acknowledges it, and treats the next byte as a command. All other traffic is left to other logic.

If the command byte carries the reset code, the decoder sends a single-cycle soft-reset pulse to the register file once the acknowledge bit of that byte has completed. Other command values, including the address-acquire form, are acknowledged as the bus convention requires, but nothing else happens. Bytes after the command are not acknowledged. A START or STOP at any point abandons a partly received sequence.

Top module: `gcall_rst_decoder`

## Requirements
- R1: After reset, ackReq and softRstPulse are both 0.
- R2: A byte of 0x00 (seven address bits zero and read/write bit 0) as the first byte after a START raises ackReq in the cycle after byteStb. ackReq stays high until the cycle after ackDoneStb.
- R3: A first byte of 0x01 (general call with read/write bit 1) is not acknowledged. No byte after it is acknowledged and no reset is issued until the next START.
- R4: Any other nonzero first byte after a START is not acknowledged, and the block stays idle until the next START.
- R5: The byte after an acknowledged general call address is acknowledged whatever its value.
- R6: A command byte of 0x06 makes softRstPulse high for exactly one cycle: the cycle after ackDoneStb for that byte.
- R7: Command bytes other than 0x06 produce no reset. This includes the address-acquire form (least significant bit 1) and values that differ from 0x06 only in upper bits.
- R8: Bytes after the command byte are neither acknowledged nor acted on, up to the next START or STOP.
- R9: A START or STOP received during a sequence abandons it. ackReq drops in the next cycle, a pending reset command is dropped, and after a START the next byte is decoded as an address again.
- R10: Bytes received with no preceding START (after reset or after a STOP) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | One-cycle strobe: START or repeated START seen |
| stopStb | input | 1 | One-cycle strobe: STOP seen |
| byteStb | input | 1 | One-cycle strobe: byteData holds a complete received byte |
| byteData | input | 8 | Received byte, first bit on the wire in bit 7 |
| ackDoneStb | input | 1 | One-cycle strobe: acknowledge bit slot finished |
| ackReq | output | 1 | Request to drive the acknowledge bit low |
| softRstPulse | output | 1 | One-cycle reset pulse to the register file |

## Verification
The main function is driven with address and command pairs. These include the valid reset pair, the general call with the read bit set, a nonzero address followed by the reset code, and command bytes of 0x00, 0x04, 0x07 (the acquire form), 0x86 and 0xFF. Together they separate a full-byte address match from a partial one, and a reset code match from a single-bit or masked match. Each pair is followed by an extra 0x06 byte to show that only the second byte counts. Directed sequences then abort the exchange with a START or STOP at each stage, and send bytes with no START at all.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_CMD,
    ST_ACK_CMD,
    ST_DRAIN
  } gcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCmd;  // capture "byte equals reset code"
    logic clearCmd;  // forget any captured command
    logic fire;      // launch the reset pulse next cycle
  } gcCtrl_t;

endpackage

// File: rtl/gcr_datapath.sv
module gcr_datapath
  import gcr_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CALL_ADDR = 8'h00,
  parameter logic [7:0]  RESET_CMD = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] byteData,
  input  gcCtrl_t           ctrl,
  output logic              addrMatch,
  output logic              cmdFlag,
  output logic              softRstPulse
);

  localparam logic [DATA_W-1:0] ADDR_KEY = DATA_W'(CALL_ADDR);
  localparam logic [DATA_W-1:0] CMD_KEY  = DATA_W'(RESET_CMD);

  logic cmdHit;

  // Whole byte compared, so the read/write bit must also match
  assign addrMatch = (byteData == ADDR_KEY);
  assign cmdHit    = (byteData == CMD_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdFlag <= 1'b0;
    end else if (ctrl.clearCmd) begin
      cmdFlag <= 1'b0;
    end else if (ctrl.latchCmd) begin
      cmdFlag <= cmdHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) softRstPulse <= 1'b0;
    else       softRstPulse <= ctrl.fire;
  end

endmodule

// File: rtl/gcr_control.sv
module gcr_control
  import gcr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    stopStb,
  input  logic    byteStb,
  input  logic    ackDoneStb,
  input  logic    addrMatch,
  input  logic    cmdFlag,
  output gcCtrl_t ctrl,
  output logic    ackReq
);

  gcState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    ctrl          = '0;
    if (stopStb) begin
      nextState     = ST_IDLE;
      ctrl.clearCmd = 1'b1;
    end else if (startStb) begin
      nextState     = ST_ADDR;
      ctrl.clearCmd = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (byteStb) nextState = addrMatch ? ST_ACK_ADDR : ST_DRAIN;
        end
        ST_ACK_ADDR: begin
          if (ackDoneStb) nextState = ST_CMD;
        end
        ST_CMD: begin
          if (byteStb) begin
            ctrl.latchCmd = 1'b1;
            nextState     = ST_ACK_CMD;
          end
        end
        ST_ACK_CMD: begin
          if (ackDoneStb) begin
            ctrl.fire     = cmdFlag;
            ctrl.clearCmd = 1'b1;
            nextState     = ST_DRAIN;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  assign ackReq = (state == ST_ACK_ADDR) || (state == ST_ACK_CMD);

endmodule

// File: rtl/gcall_rst_decoder.sv
module gcall_rst_decoder
  import gcr_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CALL_ADDR = 8'h00,
  parameter logic [7:0]  RESET_CMD = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              ackDoneStb,
  output logic              ackReq,
  output logic              softRstPulse
);

  gcCtrl_t ctrl;
  logic    addrMatch;
  logic    cmdFlag;

  gcr_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .stopStb    (stopStb),
    .byteStb    (byteStb),
    .ackDoneStb (ackDoneStb),
    .addrMatch  (addrMatch),
    .cmdFlag    (cmdFlag),
    .ctrl       (ctrl),
    .ackReq     (ackReq)
  );

  gcr_datapath #(
    .DATA_W    (DATA_W),
    .CALL_ADDR (CALL_ADDR),
    .RESET_CMD (RESET_CMD)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .byteData     (byteData),
    .ctrl         (ctrl),
    .addrMatch    (addrMatch),
    .cmdFlag      (cmdFlag),
    .softRstPulse (softRstPulse)
  );

endmodule

// File: rtl/gcr_checker.sv
module gcr_checker (
  input logic clk,
  input logic rstN,
  input logic startStb,
  input logic stopStb,
  input logic byteStb,
  input logic ackDoneStb,
  input logic ackReq,
  input logic softRstPulse
);

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse |=> !softRstPulse);

  // R6
  pulse_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse |-> $past(ackDoneStb));

  // R2
  ack_from_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackReq) |-> $past(byteStb));

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !ackDoneStb && !startStb && !stopStb) |=> ackReq);

  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startStb || stopStb) |=> (!ackReq && !softRstPulse));

endmodule

bind gcall_rst_decoder gcr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startStb     (startStb),
  .stopStb      (stopStb),
  .byteStb      (byteStb),
  .ackDoneStb   (ackDoneStb),
  .ackReq       (ackReq),
  .softRstPulse (softRstPulse)
);

// File: tb/gcall_rst_decoder_tb.sv
`timescale 1ns/1ps
module gcall_rst_decoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic       stopStb = 1'b0;
  logic       byteStb = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       ackDoneStb = 1'b0;
  logic       ackReq;
  logic       softRstPulse;

  int nChecks = 0;
  int nFails  = 0;
  int rstCount = 0;

  always #4 clk = ~clk;

  gcall_rst_decoder u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .startStb     (startStb),
    .stopStb      (stopStb),
    .byteStb      (byteStb),
    .byteData     (byteData),
    .ackDoneStb   (ackDoneStb),
    .ackReq       (ackReq),
    .softRstPulse (softRstPulse)
  );

  always @(negedge clk) if (rstN && softRstPulse) rstCount++;

  // {addr[19:12], cmd[11:4], addrAck[3], cmdAck[2], resets[1:0]}
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    20'h0006D, 20'h0004C, 20'h0007C, 20'h0000C,
    20'h01060, 20'h90060, 20'h00FFC, 20'h0086C
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart();
    startStb = 1'b1; @(negedge clk); startStb = 1'b0;
  endtask

  task automatic doStop();
    stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    byteData = d; byteStb = 1'b1; @(negedge clk); byteStb = 1'b0;
  endtask

  task automatic ackSlot();
    ackDoneStb = 1'b1; @(negedge clk); ackDoneStb = 1'b0;
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int base;
    idle(3);
    chk("R1 ackReq at reset", ackReq, 0);
    chk("R1 softRstPulse at reset", softRstPulse, 0);
    rstN = 1'b1;
    idle(2);

    // R10: byte with no START since reset
    sendByte(8'h00);
    chk("R10 no ack without START", ackReq, 0);
    ackSlot(); sendByte(8'h06); ackSlot(); idle(2);
    chk("R10 no reset without START", rstCount, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] a, c;
      int ea, ec, er;
      a = VEC[i][19:12]; c = VEC[i][11:4];
      ea = VEC[i][3]; ec = VEC[i][2]; er = int'(VEC[i][1:0]);
      base = rstCount;
      doStart();
      sendByte(a);
      chk("R2/R3/R4 address ack", ackReq, ea);
      idle(3);
      chk("R2 ack held until slot end", ackReq, ea);
      ackSlot();
      chk("R2 ack released after slot", ackReq, 0);
      sendByte(c);
      chk("R5/R3 command ack", ackReq, ec);
      ackSlot();
      chk("R6/R7 pulse right after ack slot", softRstPulse, er);
      idle(1);
      chk("R6 pulse one cycle wide", softRstPulse, 0);
      idle(1);
      chk("R6/R7 reset count", rstCount - base, er);
      sendByte(8'h06);
      chk("R8 extra byte not acked", ackReq, 0);
      ackSlot(); idle(2);
      chk("R8 extra byte no reset", rstCount - base, er);
      doStop();
      idle(1);
    end

    // R10: after STOP, bytes ignored
    base = rstCount;
    sendByte(8'h00);
    chk("R10 no ack after STOP", ackReq, 0);
    ackSlot(); sendByte(8'h06); ackSlot(); idle(2);
    chk("R10 no reset after STOP", rstCount - base, 0);

    // R9: repeated START after address ack restarts decode
    doStart(); sendByte(8'h00); ackSlot();
    doStart(); sendByte(8'h06);
    chk("R9 byte after restart is address", ackReq, 0);
    ackSlot(); idle(2);
    chk("R9 no reset after restart", rstCount - base, 0);
    doStop();

    // R9: START during address ack drops ackReq
    doStart(); sendByte(8'h00);
    chk("R9 ack before abort", ackReq, 1);
    doStart();
    chk("R9 START drops ack", ackReq, 0);
    doStop();

    // R9: STOP during command ack cancels reset
    doStart(); sendByte(8'h00); ackSlot(); sendByte(8'h06);
    chk("R9 command acked before STOP", ackReq, 1);
    doStop();
    chk("R9 STOP drops ack", ackReq, 0);
    ackSlot(); idle(2);
    chk("R9 STOP cancels reset", rstCount - base, 0);

    // R3 then R9: read form, then restart with valid reset
    doStart(); sendByte(8'h01);
    chk("R3 read form not acked", ackReq, 0);
    ackSlot(); sendByte(8'h06);
    chk("R3 following byte not acked", ackReq, 0);
    ackSlot();
    doStart(); sendByte(8'h00);
    chk("R9 restart address acked", ackReq, 1);
    ackSlot(); sendByte(8'h06); ackSlot();
    chk("R6 reset after restart", softRstPulse, 1);
    idle(2);
    chk("R6 one reset after restart", rstCount - base, 1);
    doStop();
    idle(2);
    finishRun();
  end

endmodule